// File: doc/BRIEF.md
# ROM Overlay Bank Controller

This block sits on the address and strobe lines of an 8-bit CPU with a 64 KB address space. It places 16 KB of extra RAM under the top 12 KB of that space, which ROM normally serves. The RAM is split into two 4 KB banks that share the window 0xD000–0xDFFF and one 8 KB region at 0xE000–0xFFFF. Software changes the mapping by touching one of sixteen soft-switch addresses at 0xC080–0xC08F. The low nibble of the switch address picks a mode, and bit 3 of it picks the 4 KB bank. The block does not store any data. It produces chip selects, a RAM region code and a gated RAM write strobe, all from the current access, and keeps the mapping state in registers.

RAM writes are armed by a handshake. Two read accesses to the odd-numbered arming switches, with no other switch access between them, enable writing. The arming counter is a three-state machine with the states ARM_ZERO, ARM_ONE and ARM_FULL. A read of an arming switch moves it ZERO→ONE, ONE→FULL or FULL→FULL. The move into FULL sets write enable. Any other mode access, and any write access to an arming switch, returns it to ARM_ZERO. Switch addresses that select no mode leave the machine where it is.

Top module: `rom_overlay_ctrl`

## Requirements
- R1: After reset, overlay read and write are both disabled, the arming state is ARM_ZERO and bank 2 is selected. Reads at 0xF800–0xFFFF assert rom_cs, and no access asserts ram_cs.
- R2: A read access to 0xC080–0xC08F asserts rdata_oe with rdata = 0x00 and asserts none of ram_cs, rom_cs or under_sel.
- R3: Every switch access latches address bit 3: 1 maps bank 1 (ram_region = 1) at 0xD000–0xDFFF, and 0 maps bank 2 (ram_region = 2). Accesses at 0xE000–0xFFFF give ram_region = 3. ram_region is 0 whenever ram_cs is low.
- R4: Nibble 0x0 or 0x4, read or write access: overlay read on, overlay write off, arming state to ARM_ZERO.
- R5: A read access to nibble 0x1 or 0x5 turns overlay read off and advances the arming state. Write is enabled when that state reaches ARM_FULL.
- R6: Nibble 0x2 or 0x6, read or write access: overlay read and write both off, arming state to ARM_ZERO.
- R7: A read access to nibble 0x3 or 0xB turns overlay read on and advances the arming state. Write is enabled on reaching ARM_FULL.
- R8: A write access to nibble 0x1, 0x3, 0x5 or 0xB applies that switch's read setting and returns the arming state to ARM_ZERO. It leaves write enable unchanged and never sets it.
- R9: The arming state saturates at ARM_FULL, so a third arming read keeps write enabled. Accesses outside the switch range do not break an arming sequence.
- R10: Switch nibbles 0x7, 0x8, 0x9, 0xA, 0xC, 0xD, 0xE and 0xF change neither the read/write enables nor the arming state, but they do update the bank choice.
- R11: With overlay read off, reads at 0xF800–0xFFFF assert rom_cs and reads at 0xD000–0xF7FF assert under_sel. With overlay read on, reads at 0xD000–0xFFFF assert ram_cs.
- R12: With write enable clear, a write at 0xD000–0xFFFF asserts neither ram_we nor ram_cs, and it changes no mapping state. With write enable set, such a write asserts ram_cs and ram_we.
- R13: The selects respond in the same cycle as the access. A switch access takes effect from the next clock cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | An access is present this cycle |
| bus_rnw | input | 1 | 1 = read access, 0 = write access |
| bus_addr | input | 16 | CPU address |
| ram_cs | output | 1 | Overlay RAM selected |
| ram_we | output | 1 | Gated overlay RAM write strobe |
| ram_region | output | 2 | 1 = bank 1, 2 = bank 2, 3 = upper 8 KB, 0 = none |
| rom_cs | output | 1 | ROM selected for a read |
| under_sel | output | 1 | Read falls through to the underlying memory |
| rdata_oe | output | 1 | Block drives the read data (switch reads) |
| rdata | output | 8 | Read data, always 0x00 |

## Verification
The selects (ram_cs, ram_we, ram_region, rom_cs, under_sel, rdata_oe) are combinational in the access cycle. A switch access changes the mapping only after the next rising edge, so its effect first shows on the following access. The bench drives each access just after a falling edge and compares all outputs a quarter period later, before the rising edge. It then advances its reference model at that rising edge. As a result, every comparison uses the state left by the previous cycles, and the model and the design register the switch effect at the same edge.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [2:0] {
        SW_RD_RAM  = 3'd0,   // read RAM, write off
        SW_ARM_ROM = 3'd1,   // read ROM side, arm on reads
        SW_OFF     = 3'd2,   // read and write off
        SW_ARM_RAM = 3'd3,   // read RAM, arm on reads
        SW_NOP     = 3'd4    // bank update only
    } sw_mode_e;

    typedef enum logic [1:0] {
        ARM_ZERO = 2'd0,
        ARM_ONE  = 2'd1,
        ARM_FULL = 2'd2
    } arm_e;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_BANK1 = 2'd1,
        RGN_BANK2 = 2'd2,
        RGN_HIGH  = 2'd3
    } rgn_e;

endpackage

// File: rtl/ovl_switch_decode.sv
module ovl_switch_decode
    import ovl_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] SW_BASE  = 16'hC080,
    parameter int          BANK_BIT = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output sw_mode_e          mode,
    output logic              bank1
);
    localparam int NIB_W = 4;

    logic [NIB_W-1:0] nib;

    assign nib   = addr[NIB_W-1:0];
    assign hit   = (addr[ADDR_W-1:NIB_W] == SW_BASE[ADDR_W-1:NIB_W]);
    assign bank1 = addr[BANK_BIT];

    always_comb begin
        unique case (nib)
            4'h0, 4'h4: mode = SW_RD_RAM;
            4'h1, 4'h5: mode = SW_ARM_ROM;
            4'h2, 4'h6: mode = SW_OFF;
            4'h3, 4'hB: mode = SW_ARM_RAM;
            default:    mode = SW_NOP;
        endcase
    end

endmodule

// File: rtl/ovl_arm_fsm.sv
module ovl_arm_fsm
    import ovl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sw_acc,
    input  logic     rnw,
    input  sw_mode_e mode,
    input  logic     bank1_in,
    output logic     rd_en,
    output logic     wr_en,
    output logic     bank1
);
    arm_e arm_q, arm_d;
    logic rd_d, wr_d, bank1_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= ARM_ZERO;
            rd_en <= 1'b0;
            wr_en <= 1'b0;
            bank1 <= 1'b0;
        end else begin
            arm_q <= arm_d;
            rd_en <= rd_d;
            wr_en <= wr_d;
            bank1 <= bank1_d;
        end
    end

    function automatic arm_e arm_step(input arm_e cur);
        unique case (cur)
            ARM_ZERO: arm_step = ARM_ONE;
            ARM_ONE:  arm_step = ARM_FULL;
            default:  arm_step = ARM_FULL;
        endcase
    endfunction

    // next-state and enable process
    always_comb begin
        arm_d   = arm_q;
        rd_d    = rd_en;
        wr_d    = wr_en;
        bank1_d = bank1;
        if (sw_acc) begin
            bank1_d = bank1_in;
            unique case (mode)
                SW_RD_RAM: begin
                    arm_d = ARM_ZERO;
                    rd_d  = 1'b1;
                    wr_d  = 1'b0;
                end
                SW_OFF: begin
                    arm_d = ARM_ZERO;
                    rd_d  = 1'b0;
                    wr_d  = 1'b0;
                end
                SW_ARM_ROM, SW_ARM_RAM: begin
                    rd_d = (mode == SW_ARM_RAM);
                    if (rnw) begin
                        arm_d = arm_step(arm_q);
                        if (arm_d == ARM_FULL) wr_d = 1'b1;
                    end else begin
                        arm_d = ARM_ZERO;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5 / R7: write enable rises only after an arming read
    p_arm_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(sw_acc && rnw && (mode == SW_ARM_ROM || mode == SW_ARM_RAM)));

    // R8: write access to an arming switch never enables write and clears the count
    p_arm_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && !rnw && (mode == SW_ARM_ROM || mode == SW_ARM_RAM))
        |=> (arm_q == ARM_ZERO) && (wr_en == $past(wr_en)));

    // R6: all-off switch clears both enables
    p_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && mode == SW_OFF) |=> (!rd_en && !wr_en));

    // R10: no-op switch keeps enables and count
    p_nop_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && mode == SW_NOP)
        |=> (rd_en == $past(rd_en)) && (wr_en == $past(wr_en)) && (arm_q == $past(arm_q)));

    // R9: full count always carries write enable
    p_full_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q == ARM_FULL) |-> wr_en);

endmodule

// File: rtl/ovl_map_decode.sv
module ovl_map_decode
    import ovl_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] OVL_BASE  = 16'hD000,
    parameter logic [15:0] HIGH_BASE = 16'hE000,
    parameter logic [15:0] ROM_BASE  = 16'hF800
) (
    input  logic              valid,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sw_hit,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              bank1,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [1:0]        ram_region,
    output logic              rom_cs,
    output logic              under_sel,
    output logic              rdata_oe,
    output logic [DATA_W-1:0] rdata
);
    logic in_ovl, in_high, in_rom, rd_acc, wr_acc;

    assign in_ovl  = (addr >= OVL_BASE[ADDR_W-1:0]);
    assign in_high = (addr >= HIGH_BASE[ADDR_W-1:0]);
    assign in_rom  = (addr >= ROM_BASE[ADDR_W-1:0]);
    assign rd_acc  = valid && rnw;
    assign wr_acc  = valid && !rnw;

    always_comb begin
        ram_cs     = in_ovl && ((rd_acc && rd_en) || (wr_acc && wr_en));
        ram_we     = in_ovl && wr_acc && wr_en;
        rom_cs     = rd_acc && in_rom && !rd_en;
        under_sel  = rd_acc && in_ovl && !in_rom && !rd_en;
        rdata_oe   = rd_acc && sw_hit;
        rdata      = '0;
        ram_region = RGN_NONE;
        if (ram_cs) begin
            if (in_high)    ram_region = RGN_HIGH;
            else if (bank1) ram_region = RGN_BANK1;
            else            ram_region = RGN_BANK2;
        end
    end

endmodule

// File: rtl/rom_overlay_ctrl.sv
module rom_overlay_ctrl
    import ovl_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] SW_BASE   = 16'hC080,
    parameter int          BANK_BIT  = 3,
    parameter logic [15:0] OVL_BASE  = 16'hD000,
    parameter logic [15:0] HIGH_BASE = 16'hE000,
    parameter logic [15:0] ROM_BASE  = 16'hF800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rnw,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [1:0]        ram_region,
    output logic              rom_cs,
    output logic              under_sel,
    output logic              rdata_oe,
    output logic [DATA_W-1:0] rdata
);
    logic     sw_hit, sw_bank1, rd_en, wr_en, bank1;
    sw_mode_e sw_mode;

    ovl_switch_decode #(
        .ADDR_W(ADDR_W), .SW_BASE(SW_BASE), .BANK_BIT(BANK_BIT)
    ) u_dec (
        .addr(bus_addr), .hit(sw_hit), .mode(sw_mode), .bank1(sw_bank1)
    );

    ovl_arm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sw_acc(bus_valid && sw_hit), .rnw(bus_rnw),
        .mode(sw_mode), .bank1_in(sw_bank1),
        .rd_en(rd_en), .wr_en(wr_en), .bank1(bank1)
    );

    ovl_map_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVL_BASE(OVL_BASE),
        .HIGH_BASE(HIGH_BASE), .ROM_BASE(ROM_BASE)
    ) u_map (
        .valid(bus_valid), .rnw(bus_rnw), .addr(bus_addr), .sw_hit(sw_hit),
        .rd_en(rd_en), .wr_en(wr_en), .bank1(bank1),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_region(ram_region),
        .rom_cs(rom_cs), .under_sel(under_sel),
        .rdata_oe(rdata_oe), .rdata(rdata)
    );

    // R11: at most one source answers an access
    p_one_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, rom_cs, under_sel, rdata_oe}));

    // R3: a selected RAM always carries a region code
    p_region_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> (ram_region != 2'd0));

    // R12: a strobe only accompanies a select
    p_we_with_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && !bus_rnw));

endmodule

// File: tb/test_rom_overlay_ctrl.sv
module test_rom_overlay_ctrl;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_rnw = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic        ram_cs, ram_we, rom_cs, under_sel, rdata_oe;
    logic [1:0]  ram_region;
    logic [7:0]  rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_cnt = 0;
    bit m_rd = 0, m_wr = 0, m_bank1 = 0;

    always #(PERIOD/2) clk = ~clk;

    rom_overlay_ctrl i_rom_overlay_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rnw(bus_rnw),
        .bus_addr(bus_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .ram_region(ram_region), .rom_cs(rom_cs), .under_sel(under_sel),
        .rdata_oe(rdata_oe), .rdata(rdata)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        summary();
        $finish;
    end

    function automatic logic [14:0] expect_out(logic [15:0] a, bit rd, bit v);
        bit sw, ovl, e_cs, e_we, e_rom, e_under, e_oe;
        logic [1:0] rgn;
        sw      = (a[15:4] == 12'hC08);
        ovl     = (a >= 16'hD000);
        e_oe    = v && rd && sw;
        e_cs    = v && ovl && (rd ? m_rd : m_wr);
        e_we    = v && ovl && !rd && m_wr;
        e_rom   = v && rd && (a >= 16'hF800) && !m_rd;
        e_under = v && rd && ovl && (a < 16'hF800) && !m_rd;
        rgn     = 2'd0;
        if (e_cs) rgn = (a[15:12] == 4'hD) ? (m_bank1 ? 2'd1 : 2'd2) : 2'd3;
        return {e_cs, e_we, rgn, e_rom, e_under, e_oe, 8'h00};
    endfunction

    task automatic model_step(logic [15:0] a, bit rd, bit v);
        if (v && a[15:4] == 12'hC08) begin
            m_bank1 = a[3];
            case (a[3:0])
                4'h0, 4'h4: begin m_rd = 1; m_wr = 0; m_cnt = 0; end
                4'h2, 4'h6: begin m_rd = 0; m_wr = 0; m_cnt = 0; end
                4'h1, 4'h5, 4'h3, 4'hB: begin
                    m_rd = (a[3:0] == 4'h3 || a[3:0] == 4'hB);
                    if (rd) begin
                        m_cnt++;
                        if (m_cnt >= 2) m_wr = 1;
                        if (m_cnt > 2) m_cnt = 2;
                    end else begin
                        m_cnt = 0;
                    end
                end
                default: ;
            endcase
        end
    endtask

    task automatic acc(logic [15:0] a, bit rd, bit v, string req);
        logic [14:0] act, exp_v;
        @(negedge clk);
        bus_addr = a; bus_rnw = rd; bus_valid = v;
        #(PERIOD/4);
        act   = {ram_cs, ram_we, ram_region, rom_cs, under_sel, rdata_oe, rdata};
        exp_v = expect_out(a, rd, v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s addr=%h rnw=%0d actual=%h expected=%h", req, a, rd, act, exp_v);
        end
        @(posedge clk);
        model_step(a, rd, v);
    endtask

    task automatic rd(logic [15:0] a, string req); acc(a, 1, 1, req); endtask
    task automatic wr(logic [15:0] a, string req); acc(a, 0, 1, req); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(16'hFFFC, "R1"); rd(16'hF800, "R1"); rd(16'hD000, "R11");
        rd(16'hE123, "R11"); wr(16'hD010, "R12"); wr(16'hFFF0, "R12");
        acc(16'hD000, 1, 0, "R1");
        // R2 switch reads give 0x00
        rd(16'hC08E, "R2");
        // R4 read RAM, bank 2; R13 effect next cycle
        rd(16'hC080, "R4"); rd(16'hD123, "R13"); rd(16'hF900, "R3");
        wr(16'hD123, "R12");
        // R10 no-op with bank bit set -> bank 1
        rd(16'hC088, "R10"); rd(16'hD456, "R3"); rd(16'hC087, "R10");
        rd(16'hD456, "R3");
        // R5 single arming read is not enough
        rd(16'hC081, "R5"); wr(16'hD000, "R12"); rd(16'hF900, "R11");
        rd(16'hD800, "R11");
        // R9 non-switch access between arming reads
        rd(16'hC081, "R5"); wr(16'hD000, "R5"); wr(16'hE000, "R5");
        rd(16'hFFFE, "R11");
        // R7 read RAM at bank 1, saturate
        rd(16'hC08B, "R7"); rd(16'hC08B, "R9"); rd(16'hC08B, "R9");
        rd(16'hD001, "R7"); wr(16'hDFFF, "R9");
        // R8 write access to arming switch
        wr(16'hC081, "R8"); rd(16'hD001, "R8"); wr(16'hD001, "R8");
        // R6 all off
        wr(16'hC086, "R6"); rd(16'hD001, "R6"); wr(16'hD001, "R6");
        rd(16'hFFFF, "R6");
        // R8 interrupted arming sequence stays disarmed
        rd(16'hC083, "R8"); wr(16'hC083, "R8"); rd(16'hC083, "R8");
        wr(16'hE555, "R8"); rd(16'hC083, "R7"); wr(16'hE555, "R7");
        // R4 via write access, clears write
        wr(16'hC084, "R4"); wr(16'hE555, "R4"); rd(16'hE555, "R4");
        // R10 no-op write changes bank only
        wr(16'hC08F, "R10"); rd(16'hD222, "R10"); wr(16'hC082, "R6");
        rd(16'hC085, "R5"); rd(16'hC085, "R5"); wr(16'hD333, "R5");
        rd(16'hD333, "R11"); wr(16'hC08A, "R10"); wr(16'hD333, "R10");
        rd(16'hC089, "R2");
        acc(16'h0000, 1, 0, "R13");
        summary();
        $finish;
    end

endmodule